// File: doc/BRIEF.md
# Page Access Rights and Fault Syndrome Encoder

This block decides whether one memory access may go ahead on a page and, when it may not, describes the failure. A 2-bit protection code and a key bit together give the read and write rights of the page. A no-execute bit decides the execute right. The access kind selects which of the three rights is tested. A reason code comes from the translation logic upstream. It says whether a mapping was found, and if none was found, why.

On a fault the block raises exactly one of two exception selects: the instruction storage fault for fetches, or the data storage fault for loads and stores. It also drives a 32-bit syndrome word that encodes the cause. On a data fault it copies the effective address out, so the caller can latch it. The block has no state and no clock. The caller picks the supervisor key or the problem-state key before the result reaches this block. All inputs and outputs are plain control pins, so the block has no handshake and no back-pressure. The results are valid in the same cycle as the inputs.

Top module: `pgacc_unit`

## Requirements
- R1: With key=0, protection codes 0, 1 and 2 grant read and write, and code 3 grants read only.
- R2: With key=1, code 0 grants neither read nor write, codes 1 and 3 grant read only, and code 2 grants read and write.
- R3: The execute right equals the inverse of the no-execute bit for every protection code and key.
- R4: Access kind encoding: 0 is a load and tests the read right, 1 is a store and tests the write right, 2 is a fetch and tests the execute right, and 3 is handled as a load. With reason 0 (mapping found), `granted` equals the tested right.
- R5: When `granted` is high, both exception selects are low, the syndrome is zero and `fault_addr` is zero.
- R6: When `granted` is low, exactly one exception select is high: `exc_instr` for a fetch, and `exc_data` for any other kind.
- R7: Fetch fault syndromes: 0x40000000 for no mapping, 0x08000000 for a rights violation, and 0x10000000 for a no-execute segment (reason 2) or either direct-store refusal (reasons 3, 4).
- R8: A data fault with no mapping (reason 1) gives 0x42000000 for a store and 0x40000000 for a load.
- R9: A data rights violation gives 0x0A000000 for a store and 0x08000000 for a load.
- R10: A data direct-store refusal gives 0x06000000 (store) or 0x04000000 (load) for reason 3 (reserved-pair access), and 0x06100000 (store) or 0x04100000 (load) for reason 4 (external-control access).
- R11: Reason codes 5, 6 and 7 are handled as no mapping.
- R12: On a data fault `fault_addr` equals `addr`. On a fetch fault it is zero.
- R13: Reason 2 always faults a fetch, even when the page grants execute. For a load or store, reason 2 is handled exactly like reason 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pp | input | 2 | Page protection code |
| key | input | 1 | Access key, already selected by privilege level |
| nx | input | 1 | No-execute bit of the segment |
| kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 treated as load |
| reason | input | 3 | Lookup result: 0 hit, 1 no mapping, 2 no-execute segment, 3 reserved-pair direct-store, 4 external-control direct-store |
| addr | input | ADDR_W | Effective address of the access |
| rd_ok | output | 1 | Read right granted by the page |
| wr_ok | output | 1 | Write right granted by the page |
| ex_ok | output | 1 | Execute right granted by the page |
| granted | output | 1 | Access may proceed |
| exc_instr | output | 1 | Instruction storage fault select |
| exc_data | output | 1 | Data storage fault select |
| syndrome | output | 32 | Fault cause word, zero when granted |
| fault_addr | output | ADDR_W | Faulting address on a data fault, otherwise zero |

## Verification
Two cases are hard to reach. The first is reason 2 on a fetch to a page that grants execute. The second is reason 2 on a store or load, where the no-execute segment must not count at all. Both need a precise mix of reason, kind and protection inputs. The stimulus therefore sweeps every combination of protection code, key, no-execute bit, access kind and all eight reason codes. Random addresses then show whether the address is copied out or held at zero. A constrained random phase follows that favours reason 0 and reason 2 with store and fetch kinds.

// File: rtl/pgacc_pkg.sv
package pgacc_pkg;

  localparam int SYN_W = 32;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] RSN_HIT   = 3'd0;
  localparam logic [2:0] RSN_NOMAP = 3'd1;
  localparam logic [2:0] RSN_NXSEG = 3'd2;
  localparam logic [2:0] RSN_DSRSV = 3'd3;
  localparam logic [2:0] RSN_DSEXT = 3'd4;

  // Syndrome building blocks; data values are composed from them.
  localparam logic [SYN_W-1:0] SYN_MISS   = 32'h4000_0000;
  localparam logic [SYN_W-1:0] SYN_NXDS   = 32'h1000_0000;
  localparam logic [SYN_W-1:0] SYN_PROT   = 32'h0800_0000;
  localparam logic [SYN_W-1:0] SYN_DSDATA = 32'h0400_0000;
  localparam logic [SYN_W-1:0] SYN_STORE  = 32'h0200_0000;
  localparam logic [SYN_W-1:0] SYN_EXTCTL = 32'h0010_0000;

  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_NOMAP = 3'd1,
    CS_PROT  = 3'd2,
    CS_NX    = 3'd3,
    CS_DSRSV = 3'd4,
    CS_DSEXT = 3'd5
  } cause_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

endpackage

// File: rtl/pgacc_rights.sv
module pgacc_rights
  import pgacc_pkg::*;
(
  input  logic [1:0] pp,
  input  logic       key,
  input  logic       nx,
  output rights_t    rights
);

  logic rd_l, wr_l;

  always_comb begin
    rd_l = 1'b1;
    wr_l = 1'b0;
    if (!key) begin
      wr_l = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0: begin rd_l = 1'b0; wr_l = 1'b0; end
        2'd2: wr_l = 1'b1;
        default: wr_l = 1'b0;
      endcase
    end
  end

  assign rights.rd = rd_l;
  assign rights.wr = wr_l;
  assign rights.ex = ~nx;

endmodule

// File: rtl/pgacc_judge.sv
module pgacc_judge
  import pgacc_pkg::*;
(
  input  rights_t    rights,
  input  logic [1:0] kind,
  input  logic [2:0] reason,
  output cause_e     cause
);

  logic is_fetch, is_store, need_ok;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_store = (kind == KIND_STORE);

  always_comb begin
    if (is_fetch)      need_ok = rights.ex;
    else if (is_store) need_ok = rights.wr;
    else               need_ok = rights.rd;
  end

  always_comb begin
    unique case (reason)
      RSN_HIT:   cause = need_ok ? CS_NONE : CS_PROT;
      RSN_NXSEG: cause = is_fetch ? CS_NX : (need_ok ? CS_NONE : CS_PROT);
      RSN_DSRSV: cause = CS_DSRSV;
      RSN_DSEXT: cause = CS_DSEXT;
      default:   cause = CS_NOMAP;
    endcase
  end

endmodule

// File: rtl/pgacc_syndrome.sv
module pgacc_syndrome
  import pgacc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  cause_e             cause,
  input  logic [1:0]         kind,
  input  logic [ADDR_W-1:0]  addr,
  output logic               granted,
  output logic               exc_instr,
  output logic               exc_data,
  output logic [SYN_W-1:0]   syndrome,
  output logic [ADDR_W-1:0]  fault_addr
);

  logic is_fetch, is_store, fault;
  logic [SYN_W-1:0] st_bit;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_store = (kind == KIND_STORE);
  assign fault    = (cause != CS_NONE);
  assign st_bit   = is_store ? SYN_STORE : '0;

  assign granted   = ~fault;
  assign exc_instr = fault & is_fetch;
  assign exc_data  = fault & ~is_fetch;
  assign fault_addr = exc_data ? addr : '0;

  always_comb begin
    syndrome = '0;
    if (is_fetch) begin
      unique case (cause)
        CS_NOMAP: syndrome = SYN_MISS;
        CS_PROT:  syndrome = SYN_PROT;
        CS_NX, CS_DSRSV, CS_DSEXT: syndrome = SYN_NXDS;
        default:  syndrome = '0;
      endcase
    end else begin
      unique case (cause)
        CS_NOMAP: syndrome = SYN_MISS | st_bit;
        CS_PROT:  syndrome = SYN_PROT | st_bit;
        CS_DSRSV: syndrome = SYN_DSDATA | st_bit;
        CS_DSEXT: syndrome = SYN_DSDATA | SYN_EXTCTL | st_bit;
        default:  syndrome = '0;
      endcase
    end
  end

endmodule

// File: rtl/pgacc_unit.sv
module pgacc_unit
  import pgacc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        pp,
  input  logic              key,
  input  logic              nx,
  input  logic [1:0]        kind,
  input  logic [2:0]        reason,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              ex_ok,
  output logic              granted,
  output logic              exc_instr,
  output logic              exc_data,
  output logic [31:0]       syndrome,
  output logic [ADDR_W-1:0] fault_addr
);

  rights_t rights;
  cause_e  cause;

  pgacc_rights u_rights (
    .pp     (pp),
    .key    (key),
    .nx     (nx),
    .rights (rights)
  );

  pgacc_judge u_judge (
    .rights (rights),
    .kind   (kind),
    .reason (reason),
    .cause  (cause)
  );

  pgacc_syndrome #(.ADDR_W(ADDR_W)) u_syn (
    .cause      (cause),
    .kind       (kind),
    .addr       (addr),
    .granted    (granted),
    .exc_instr  (exc_instr),
    .exc_data   (exc_data),
    .syndrome   (syndrome),
    .fault_addr (fault_addr)
  );

  assign rd_ok = rights.rd;
  assign wr_ok = rights.wr;
  assign ex_ok = rights.ex;

endmodule

// File: rtl/pgacc_unit_chk.sv
module pgacc_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic [1:0]        pp,
  input logic              key,
  input logic              nx,
  input logic [1:0]        kind,
  input logic [2:0]        reason,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_ok,
  input logic              wr_ok,
  input logic              ex_ok,
  input logic              granted,
  input logic              exc_instr,
  input logic              exc_data,
  input logic [31:0]       syndrome,
  input logic [ADDR_W-1:0] fault_addr
);

  logic known;
  assign known = !$isunknown({pp, key, nx, kind, reason});

  always_comb begin
    if (known) begin
      // R2
      key_zero_code_chk: assert (!(key && pp == 2'd0) || (!rd_ok && !wr_ok));
      // R3
      exec_right_chk: assert (ex_ok == ~nx);
      // R4
      store_test_chk: assert (!(reason == 3'd0 && kind == 2'd1) || (granted == wr_ok));
      // R5
      clean_grant_chk: assert (!granted || (!exc_instr && !exc_data && syndrome == 32'd0));
      // R6
      one_outcome_chk: assert ($countones({granted, exc_instr, exc_data}) == 1);
      // R12
      data_addr_chk: assert (!exc_data || fault_addr == addr);
      // R13
      nxseg_fetch_chk: assert (!(reason == 3'd2 && kind == 2'd2) || exc_instr);
    end
  end

endmodule

bind pgacc_unit pgacc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pp(pp), .key(key), .nx(nx), .kind(kind), .reason(reason), .addr(addr),
  .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok), .granted(granted),
  .exc_instr(exc_instr), .exc_data(exc_data), .syndrome(syndrome),
  .fault_addr(fault_addr)
);

// File: tb/pgacc_unit_bench.sv
module pgacc_unit_bench;

  localparam int AW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    pp = '0;
  logic          key = 1'b0, nx = 1'b0;
  logic [1:0]    kind = '0;
  logic [2:0]    reason = '0;
  logic [AW-1:0] addr = '0;
  logic          rd_ok, wr_ok, ex_ok, granted, exc_instr, exc_data;
  logic [31:0]   syndrome;
  logic [AW-1:0] fault_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pgacc_unit #(.ADDR_W(AW)) u_pgacc_unit (
    .pp(pp), .key(key), .nx(nx), .kind(kind), .reason(reason), .addr(addr),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok), .granted(granted),
    .exc_instr(exc_instr), .exc_data(exc_data), .syndrome(syndrome),
    .fault_addr(fault_addr)
  );

  // Reference rights: {rd, wr}
  function automatic logic [1:0] ref_rw(input logic [1:0] p, input logic k);
    if (!k) return (p == 2'd3) ? 2'b10 : 2'b11;
    case (p)
      2'd0: return 2'b00;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  // Reference cause: 0 none, 1 nomap, 2 prot, 3 nx, 4 rsv, 5 ext
  function automatic int ref_cause(input logic [1:0] p, input logic k, input logic n,
                                   input logic [1:0] kd, input logic [2:0] rs);
    logic [1:0] rw;
    logic ok;
    rw = ref_rw(p, k);
    ok = (kd == 2'd2) ? ~n : (kd == 2'd1) ? rw[0] : rw[1];
    case (rs)
      3'd0: return ok ? 0 : 2;
      3'd2: return (kd == 2'd2) ? 3 : (ok ? 0 : 2);
      3'd3: return 4;
      3'd4: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] ref_syn(input int c, input logic [1:0] kd);
    if (kd == 2'd2) begin
      case (c)
        1: return 32'h4000_0000;
        2: return 32'h0800_0000;
        3, 4, 5: return 32'h1000_0000;
        default: return 32'h0;
      endcase
    end
    case (c)
      1: return (kd == 2'd1) ? 32'h4200_0000 : 32'h4000_0000;
      2: return (kd == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000;
      4: return (kd == 2'd1) ? 32'h0600_0000 : 32'h0400_0000;
      5: return (kd == 2'd1) ? 32'h0610_0000 : 32'h0410_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string syn_req(input int c, input logic [1:0] kd, input logic [2:0] rs);
    if (rs >= 3'd5) return "R11";
    if (rs == 3'd2) return "R13";
    if (c == 0) return "R5";
    if (kd == 2'd2) return "R7";
    case (c)
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h (pp=%0d key=%0d nx=%0d kind=%0d reason=%0d)",
               req, what, act, exp, pp, key, nx, kind, reason);
    end
  endtask

  task automatic run(input logic [1:0] p, input logic k, input logic n,
                     input logic [1:0] kd, input logic [2:0] rs, input logic [AW-1:0] a);
    logic [1:0] rw;
    int c;
    logic fetch;
    @(posedge clk);
    pp = p; key = k; nx = n; kind = kd; reason = rs; addr = a;
    @(negedge clk);
    rw = ref_rw(p, k);
    c = ref_cause(p, k, n, kd, rs);
    fetch = (kd == 2'd2);
    cmp(k ? "R2" : "R1", "rights", {30'd0, rd_ok, wr_ok}, {30'd0, rw});
    cmp("R3", "ex_ok", {31'd0, ex_ok}, {31'd0, ~n});
    cmp((rs == 3'd2) ? "R13" : "R4", "granted", {31'd0, granted}, {31'd0, c == 0});
    cmp((c == 0) ? "R5" : "R6", "exc_sel", {30'd0, exc_instr, exc_data},
        {30'd0, (c != 0) && fetch, (c != 0) && !fetch});
    cmp(syn_req(c, kd, rs), "syndrome", syndrome, ref_syn(c, kd));
    cmp("R12", "fault_addr", fault_addr, ((c != 0) && !fetch) ? a : '0);
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    // reset-like idle state: all inputs zero is a granted load
    @(negedge clk);
    cmp("R5", "idle granted", {31'd0, granted}, 32'd1);
    cmp("R5", "idle syndrome", syndrome, 32'd0);

    // Directed corners
    run(2'd1, 1'b0, 1'b0, 2'd2, 3'd2, 32'hDEAD_BEEF);  // R13 fetch on nx segment
    run(2'd3, 1'b0, 1'b1, 2'd1, 3'd2, 32'h1234_5678);  // R13 store treated as hit -> R9
    run(2'd0, 1'b1, 1'b0, 2'd0, 3'd0, 32'hCAFE_0000);  // R2 key=1 code 0 denies load
    run(2'd2, 1'b1, 1'b0, 2'd1, 3'd0, 32'h0000_1000);  // R2 store granted
    run(2'd3, 1'b1, 1'b0, 2'd3, 3'd4, 32'hFFFF_FFFF);  // R10 kind 3 as load
    run(2'd0, 1'b0, 1'b0, 2'd1, 3'd7, 32'h8000_0001);  // R11

    // Exhaustive sweep
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 2; k++)
        for (int n = 0; n < 2; n++)
          for (int kd = 0; kd < 4; kd++)
            for (int rs = 0; rs < 8; rs++)
              run(p[1:0], k[0], n[0], kd[1:0], rs[2:0], $urandom);

    // Constrained random, biased to reasons 0 and 2 with store/fetch
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] rs;
      logic [1:0] kd;
      rs = ($urandom % 4 != 0) ? (($urandom % 2) ? 3'd0 : 3'd2) : 3'($urandom % 8);
      kd = ($urandom % 3 != 0) ? (($urandom % 2) ? 2'd1 : 2'd2) : 2'($urandom % 4);
      run(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), kd, rs, $urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule